// File: doc/BRIEF.md
# 16-bit Memory Operand Address Generator

This block turns the addressing byte of a 16-bit instruction and its displacement field into the effective address of the memory operand. It takes the current values of the four 16-bit pointer registers (BX, BP, SI, DI) as plain inputs. It picks zero, one or two of them from the rm field and adds the displacement form chosen by the mod field. All sums wrap at 16 bits. It also raises a flag when the chosen form is based on BP, so that a later stage can use the stack segment by default. Register-direct forms cannot address memory. The block marks them as illegal and does not return a usable address for them.

Operands enter through a valid/ready handshake. Each accepted request produces one registered result, and that result has its own valid/ready handshake. A result stays on the output, unchanged, until the consumer takes it. While a result waits and the consumer is not ready, the input ready is low. When the consumer takes the pending result in the same cycle, a new request can be accepted, so the stream runs at one item per cycle with no gaps.

Top module: `ea16_agen`

## Requirements
- R1: When mod=00 and rm=110, the address equals the 16-bit displacement, with no register added. The BP-based flag is 0 in this case. The byte is laid out as mod in bits 7:6, a don't-care register field in bits 5:3, and rm in bits 2:0.
- R2: When mod=00 and rm is not 110, no displacement is added, whatever the displacement input holds.
- R3: When mod=01, bits 7:0 of the displacement are sign-extended to 16 bits and added. Displacement bits 15:8 have no effect.
- R4: When mod=10, the full 16-bit displacement is added.
- R5: The rm field selects the registers as follows: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. Bits 5:3 of the byte have no effect.
- R6: All additions wrap modulo 2^16.
- R7: When mod=11, the result has the illegal flag set, address 0 and BP-based flag 0. Every memory form has the illegal flag clear.
- R8: The BP-based flag is 1 for rm=010 and rm=011 under mod 00, 01 or 10, and for rm=110 under mod 01 or 10. It is 0 for every other form.
- R9: An input accepted at a clock edge (in_valid and in_ready both high) appears at the output, with out_valid high, after that edge. The result stays valid and unchanged until the edge at which out_ready is high.
- R10: in_ready is high exactly when no result is pending or when out_ready is high.
- R11: When rst_n is low at a clock edge, out_valid is low after that edge, and any pending result is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_modrm | input | 8 | Addressing byte: mod in bits 7:6, rm in bits 2:0 |
| in_disp | input | 16 | Displacement field (only bits 7:0 are used when mod=01) |
| in_bx | input | 16 | BX register value |
| in_bp | input | 16 | BP register value |
| in_si | input | 16 | SI register value |
| in_di | input | 16 | DI register value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Effective address (0 for illegal forms) |
| out_stack_seg | output | 1 | Address is based on BP |
| out_illegal | output | 1 | Request was a register-direct form |

## Verification
A wrong register selection or a wrong displacement form shows up at the output as a wrong address on the very result that used it, one cycle after acceptance. Because of this, every rm and mod pair is compared against an independent model. A corrupted output register or a broken hold path shows up as a result that changes, vanishes or repeats while out_ready is low, or as a missing item in the scoreboard order. Errors in the ready path show up in the same cycle as a mismatch between in_ready and the pending state. A stale result left behind by reset shows up as an extra item in the first cycle after reset.

// File: rtl/ea16_pkg.sv
package ea16_pkg;

  // Register source for one term of the sum
  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_BX   = 3'd1,
    SRC_BP   = 3'd2,
    SRC_SI   = 3'd3,
    SRC_DI   = 3'd4
  } reg_src_e;

  // Displacement treatment
  typedef enum logic [1:0] {
    DSP_NONE  = 2'd0,
    DSP_SHORT = 2'd1,
    DSP_FULL  = 2'd2
  } disp_kind_e;

  // Decoded control for one request
  typedef struct packed {
    reg_src_e   base_sel;
    reg_src_e   index_sel;
    disp_kind_e dkind;
    logic       stack;
    logic       illegal;
  } ea_ctrl_t;

  localparam int unsigned NUM_TERMS = 2;

endpackage

// File: rtl/ea16_decode.sv
module ea16_decode
  import ea16_pkg::*;
(
  input  logic [1:0] mod_f,
  input  logic [2:0] rm_f,
  output ea_ctrl_t   ctrl
);

  always_comb begin
    ctrl = '{base_sel: SRC_ZERO, index_sel: SRC_ZERO, dkind: DSP_NONE,
             stack: 1'b0, illegal: 1'b0};
    if (mod_f == 2'b11) begin
      // register-direct: no memory address
      ctrl.illegal = 1'b1;
    end else if (mod_f == 2'b00 && rm_f == 3'b110) begin
      // direct displacement only
      ctrl.dkind = DSP_FULL;
    end else begin
      unique case (mod_f)
        2'b01:   ctrl.dkind = DSP_SHORT;
        2'b10:   ctrl.dkind = DSP_FULL;
        default: ctrl.dkind = DSP_NONE;
      endcase
      unique case (rm_f)
        3'b000: begin ctrl.base_sel = SRC_BX; ctrl.index_sel = SRC_SI; end
        3'b001: begin ctrl.base_sel = SRC_BX; ctrl.index_sel = SRC_DI; end
        3'b010: begin ctrl.base_sel = SRC_BP; ctrl.index_sel = SRC_SI; ctrl.stack = 1'b1; end
        3'b011: begin ctrl.base_sel = SRC_BP; ctrl.index_sel = SRC_DI; ctrl.stack = 1'b1; end
        3'b100: ctrl.index_sel = SRC_SI;
        3'b101: ctrl.index_sel = SRC_DI;
        3'b110: begin ctrl.base_sel = SRC_BP; ctrl.stack = 1'b1; end
        default: ctrl.base_sel = SRC_BX;
      endcase
    end
  end

endmodule

// File: rtl/ea16_reg_pick.sv
module ea16_reg_pick
  import ea16_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  reg_src_e          sel,
  input  logic [ADDR_W-1:0] bx,
  input  logic [ADDR_W-1:0] bp,
  input  logic [ADDR_W-1:0] si,
  input  logic [ADDR_W-1:0] di,
  output logic [ADDR_W-1:0] val
);

  always_comb begin
    unique case (sel)
      SRC_BX:  val = bx;
      SRC_BP:  val = bp;
      SRC_SI:  val = si;
      SRC_DI:  val = di;
      default: val = '0;
    endcase
  end

endmodule

// File: rtl/ea16_sum.sv
module ea16_sum
  import ea16_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] term_a,
  input  logic [ADDR_W-1:0] term_b,
  input  logic [ADDR_W-1:0] disp,
  input  disp_kind_e        dkind,
  output logic [ADDR_W-1:0] sum
);

  localparam int unsigned EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] disp_term;

  always_comb begin
    unique case (dkind)
      DSP_SHORT: disp_term = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      DSP_FULL:  disp_term = disp;
      default:   disp_term = '0;
    endcase
  end

  // modular add, carry out discarded
  assign sum = term_a + term_b + disp_term;

endmodule

// File: rtl/ea16_out_stage.sv
module ea16_out_stage #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_stack,
  input  logic              load_illegal,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_stack,
  output logic              q_illegal
);

  logic take;

  assign load_ready = ~q_valid | q_ready;
  assign take       = load_valid & load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_addr    <= '0;
      q_stack   <= 1'b0;
      q_illegal <= 1'b0;
    end else if (take) begin
      q_valid   <= 1'b1;
      q_addr    <= load_addr;
      q_stack   <= load_stack;
      q_illegal <= load_illegal;
    end else if (q_ready) begin
      q_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/ea16_agen.sv
module ea16_agen
  import ea16_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_modrm,
  input  logic [ADDR_W-1:0] in_disp,
  input  logic [ADDR_W-1:0] in_bx,
  input  logic [ADDR_W-1:0] in_bp,
  input  logic [ADDR_W-1:0] in_si,
  input  logic [ADDR_W-1:0] in_di,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_stack_seg,
  output logic              out_illegal
);

  ea_ctrl_t          ctrl;
  reg_src_e          sel_arr  [NUM_TERMS];
  logic [ADDR_W-1:0] term_arr [NUM_TERMS];
  logic [ADDR_W-1:0] ea_next;

  ea16_decode u_decode (
    .mod_f (in_modrm[7:6]),
    .rm_f  (in_modrm[2:0]),
    .ctrl  (ctrl)
  );

  assign sel_arr[0] = ctrl.base_sel;
  assign sel_arr[1] = ctrl.index_sel;

  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
    ea16_reg_pick #(.ADDR_W(ADDR_W)) u_pick (
      .sel (sel_arr[g]),
      .bx  (in_bx),
      .bp  (in_bp),
      .si  (in_si),
      .di  (in_di),
      .val (term_arr[g])
    );
  end

  ea16_sum #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_sum (
    .term_a (term_arr[0]),
    .term_b (term_arr[1]),
    .disp   (in_disp),
    .dkind  (ctrl.dkind),
    .sum    (ea_next)
  );

  ea16_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_valid   (in_valid),
    .load_ready   (in_ready),
    .load_addr    (ea_next),
    .load_stack   (ctrl.stack),
    .load_illegal (ctrl.illegal),
    .q_valid      (out_valid),
    .q_ready      (out_ready),
    .q_addr       (out_addr),
    .q_stack      (out_stack_seg),
    .q_illegal    (out_illegal)
  );

endmodule

// File: rtl/ea16_agen_chk.sv
module ea16_agen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_stack_seg,
  input logic              out_illegal
);

  // R7: illegal results carry zero address and no stack flag
  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_addr == '0 && !out_stack_seg));

  // R8: stack flag never accompanies an illegal form
  assert_stack_not_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_stack_seg) |-> !out_illegal);

  // R9: accepted request yields a valid result next cycle
  assert_accept_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: a stalled result holds its value
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
      && $stable(out_stack_seg) && $stable(out_illegal)));

  // R10: back-pressure blocks input
  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: an empty output stage is always ready
  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R11: reset empties the output stage
  assert_reset_clears_R11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind ea16_agen ea16_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_stack_seg (out_stack_seg),
  .out_illegal   (out_illegal)
);

// File: tb/test_ea16_agen.sv
`timescale 1ns/1ps
module test_ea16_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_modrm = '0;
  logic [15:0] in_disp = '0;
  logic [15:0] in_bx = '0, in_bp = '0, in_si = '0, in_di = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_addr;
  logic        out_stack_seg;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  int bp_mode = 0;   // 0 always ready, 1 random, 2 never
  bit done = 1'b0;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  ea16_agen i_ea16_agen (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_modrm(in_modrm), .in_disp(in_disp),
    .in_bx(in_bx), .in_bp(in_bp), .in_si(in_si), .in_di(in_di),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_stack_seg(out_stack_seg), .out_illegal(out_illegal)
  );

  // Reference model: {illegal, stack, addr}
  function automatic logic [17:0] model(input logic [7:0] m, input logic [15:0] d,
      input logic [15:0] bx, input logic [15:0] bp, input logic [15:0] si,
      input logic [15:0] di);
    logic [1:0]  md = m[7:6];
    logic [2:0]  rm = m[2:0];
    logic [15:0] a;
    logic [15:0] off;
    logic        stk;
    if (md == 2'd3) return {1'b1, 1'b0, 16'h0000};          // R7
    if (md == 2'd0 && rm == 3'd6) return {1'b0, 1'b0, d};    // R1
    case (rm)                                                // R5
      3'd0: a = bx + si;
      3'd1: a = bx + di;
      3'd2: a = bp + si;
      3'd3: a = bp + di;
      3'd4: a = si;
      3'd5: a = di;
      3'd6: a = bp;
      default: a = bx;
    endcase
    if (md == 2'd1) off = {{8{d[7]}}, d[7:0]};               // R3
    else if (md == 2'd2) off = d;                            // R4
    else off = 16'h0000;                                     // R2
    stk = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6);      // R8
    return {1'b0, stk, 16'(a + off)};                        // R6
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: call at posedge+1; leaves in_valid high on return
  task automatic send(input string tag, input logic [7:0] m, input logic [15:0] d,
      input logic [15:0] bx, input logic [15:0] bp, input logic [15:0] si,
      input logic [15:0] di);
    bit acc;
    in_valid = 1'b1; in_modrm = m; in_disp = d;
    in_bx = bx; in_bp = bp; in_si = si; in_di = di;
    exp_q.push_back(model(m, d, bx, bp, si, di));
    tag_q.push_back(tag);
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // Back-pressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      case (bp_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 3) != 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // Monitor / scoreboard
  initial begin
    bit          prev_hold = 1'b0;
    logic [17:0] prev_res = '0;
    logic [17:0] res;
    logic [17:0] e;
    string       t;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_hold = 1'b0;
        continue;
      end
      res = {out_illegal, out_stack_seg, out_addr};
      // R10: ready rule
      check("R10 in_ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
      // R9: stalled result held
      if (prev_hold) check("R9 hold", {13'd0, out_valid, res}, {13'd0, 1'b1, prev_res});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9: unexpected result %h, expected none", res);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {14'd0, res}, {14'd0, e});
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_res  = res;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5/R2: every rm with mod 00, reg field varied
    for (int r = 0; r < 8; r++)
      if (r != 6)
        send("R5 R2 mod00", {2'b00, 3'(r + 3), 3'(r)}, 16'h7777,
             16'h1000, 16'h2200, 16'h0030, 16'h0004);
    // R1: direct form, regs must not matter
    send("R1 direct", 8'b00_101_110, 16'hBEEF, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    // R3: short displacement, negative and positive, junk upper byte
    for (int r = 0; r < 8; r++)
      send("R3 R5 mod01", {2'b01, 3'd0, 3'(r)}, 16'hA580,
           16'h1000, 16'h2200, 16'h0030, 16'h0004);
    send("R3 positive", 8'b01_000_111, 16'hFF7F, 16'h0100, 16'h0, 16'h0, 16'h0);
    // R4: full displacement
    for (int r = 0; r < 8; r++)
      send("R4 R5 mod10", {2'b10, 3'd7, 3'(r)}, 16'h8123,
           16'h1000, 16'h2200, 16'h0030, 16'h0004);
    // R6: wraparound
    send("R6 wrap", 8'b10_000_000, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0002, 16'h0);
    send("R6 wrap neg", 8'b01_000_110, 16'h00F0, 16'h0, 16'h0005, 16'h0, 16'h0);
    // R7: register-direct forms
    send("R7 illegal", 8'b11_000_110, 16'h1234, 16'h1, 16'h2, 16'h3, 16'h4);
    send("R7 illegal", 8'b11_010_001, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    // R8: stack flag forms with BP
    send("R8 bp mod01", 8'b01_000_110, 16'h0002, 16'h0, 16'h4000, 16'h0, 16'h0);
    idle(4);

    // R9/R10: random traffic under back-pressure
    bp_mode = 1;
    for (int i = 0; i < 300; i++)
      send("R9 R10 random", 8'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom));
    idle(2);
    bp_mode = 0;
    idle(10);
    check("R9 drained", exp_q.size(), 32'd0);

    // R11: reset discards a stalled result
    bp_mode = 2;
    idle(1);
    send("R11 pending", 8'b10_000_100, 16'h0010, 16'h0, 16'h0, 16'h0100, 16'h0);
    idle(2);
    @(negedge clk);
    check("R11 pending held", {31'd0, out_valid}, 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    exp_q.delete(); tag_q.delete();
    rst_n = 1'b1;
    bp_mode = 0;
    @(negedge clk);
    check("R11 cleared", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #1;
    send("R11 after reset", 8'b00_000_101, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0042);
    idle(4);
    check("R11 drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule